// File: doc/BRIEF.md
# Debug Abstract Command Engine

This block carries out register-access commands that an external debugger issues to a halted hart. It sits behind a small debug register bus with a 7-bit address, 32-bit write data, a write strobe and a read strobe. On that bus it exposes three things: a command register, a control/status register and a bank of 32-bit argument words. A write to the command register is decoded. The block then either raises an error or runs a short sequence.

The sequence can include a register move over a valid/ready request port toward the hart and a single program-buffer run requested after the move. The argument words are the source of a register write and the destination of a register read. Quick-access commands are always refused.

The engine is a four-state machine:

- `ST_IDLE`: the engine waits for a command.
- `ST_XFER`: the hart request is held valid.
- `ST_PEXEC`: a program-buffer run is requested.
- `ST_FINISH`: a one-cycle closing state.

The transitions are:

- **start-transfer**: `ST_IDLE`→`ST_XFER`, for an accepted command with transfer set.
- **start-exec**: `ST_IDLE`→`ST_PEXEC`, for an accepted command with only postexec set.
- **start-empty**: `ST_IDLE`→`ST_FINISH`, for an accepted command with neither set.
- **xfer-to-exec**: `ST_XFER`→`ST_PEXEC`, on handshake with postexec set.
- **xfer-done**: `ST_XFER`→`ST_FINISH`, on handshake without postexec.
- **exec-done**: `ST_PEXEC`→`ST_FINISH`, on the done pulse.
- **retire**: `ST_FINISH`→`ST_IDLE`.

Top module: `abscmd_engine`

## Requirements
- R1: Address 0x16 reads as the status word: bits 3:0 hold the argument word count (`DATA_COUNT`, default 2), bits 28:24 hold the program buffer size (`PROGBUF_WORDS`, default 2), bits 10:8 hold the command error and bit 12 holds busy. All other bits read 0. After reset the word is 0x02000002, and the argument words at 0x04 and upward read 0. Read data appears the cycle after the read strobe.
- R2: A command written to 0x17 is laid out as follows: bits 31:24 are the type, with 0 meaning register access; bits 22:20 are the size; bit 18 is postexec; bit 17 is transfer; bit 16 is write; bits 15:0 are the register number. An accepted command with transfer=1 raises `hreg_valid` in the cycle after the write. At that point it presents the register number, the size and the write bit. It also presents `hreg_region`: 0 for 0x0000–0x0FFF, 1 for 0x1000–0x101F, 2 for 0x1020–0x103F and 3 for any other number below 0xC000.
- R3: When a read (write=0) completes its handshake, the low 32 bits of `hreg_rdata` go to the word at 0x04. For size 3 the upper 32 bits go to the word at 0x05. For size 2 the word at 0x05 is left unchanged.
- R4: For a write (write=1), `hreg_wdata` carries the word at 0x04 in its low half. The upper half carries the word at 0x05 for size 3 and is zero for size 2.
- R5: While `hreg_valid` is high and `hreg_ready` is low, the request and all of its fields stay unchanged.
- R6: With transfer=0, no hart request is made, and the size and register number are not checked.
- R7: With postexec=1, `pexec_req` rises after the transfer, or straight away when there is no transfer. It stays high until `pexec_done`, and it is requested once per command. It is never high together with `hreg_valid`.
- R8: Busy (status bit 12) reads 1 from the cycle after an accepted command write until the command retires. It reads 0 again one cycle after the last completion event.
- R9: While busy, a write to the command register or to an argument word is ignored and sets the error to 1.
- R10: The error becomes 2 for any of these cases: a type other than 0; transfer=1 with a size other than 2 or 3; transfer=1 with a register number of 0xC000 or above. This check wins over the halt check.
- R11: The error becomes 4 when `hart_halted` is low and the command is otherwise valid.
- R12: The error is sticky. Writing 1 to a bit of field 10:8 at 0x16 clears only that bit. While the error is nonzero, command writes start nothing and leave the error unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_addr | input | 7 | Debug bus word address |
| dbg_wdata | input | 32 | Debug bus write data |
| dbg_wr | input | 1 | Debug bus write strobe |
| dbg_rd | input | 1 | Debug bus read strobe |
| dbg_rdata | output | 32 | Registered read data |
| hart_halted | input | 1 | Hart is halted |
| hreg_valid | output | 1 | Register access request |
| hreg_ready | input | 1 | Hart accepts the request |
| hreg_write | output | 1 | 1: write register, 0: read register |
| hreg_regno | output | 16 | Register number |
| hreg_region | output | 2 | Register space of the number |
| hreg_size | output | 3 | Access size code |
| hreg_wdata | output | 64 | Write data to the hart |
| hreg_rdata | input | 64 | Read data from the hart, taken at handshake |
| pexec_req | output | 1 | Program buffer run request |
| pexec_done | input | 1 | Program buffer run finished |

## Verification
Refused commands are checked at the port. A quick-access word sent to a running hart must report 2, not 4; an engine with the checks in the wrong order would report the halt error instead. A stalled handshake is used to write new argument data and a second command while busy. An engine that failed to guard these would corrupt the write data or restart with the wrong register number. Partial write-1-to-clear of a two-bit-wide error exposes an engine that clears the whole field on any write. A 32-bit read after a 64-bit read exposes one that overwrites the upper argument word. A postexec-only command whose done pulse is held back for several cycles exposes an engine that retires without waiting.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

    localparam int          BUS_AW         = 7;
    localparam logic [6:0]  ADDR_ARG_BASE  = 7'h04;
    localparam logic [6:0]  ADDR_STATUS    = 7'h16;
    localparam logic [6:0]  ADDR_COMMAND   = 7'h17;

    localparam logic [2:0]  ERR_NONE       = 3'd0;
    localparam logic [2:0]  ERR_BUSY       = 3'd1;
    localparam logic [2:0]  ERR_UNSUP      = 3'd2;
    localparam logic [2:0]  ERR_NOT_HALTED = 3'd4;

    typedef enum logic [1:0] {
        REG_CSR   = 2'd0,
        REG_GPR   = 2'd1,
        REG_FPR   = 2'd2,
        REG_OTHER = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PEXEC,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic [2:0]  size;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
        region_e     region;
    } cmd_t;

endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
    import abscmd_pkg::*;
#(
    parameter int DATA_COUNT = 2
) (
    input  logic [31:0] cmd_word,
    input  logic        hart_halted,
    output logic [2:0]  dec_err,
    output cmd_t        dec_cmd
);
    localparam int MAX_SIZE = 2 + $clog2(DATA_COUNT);

    logic [7:0] ctype;
    logic       size_ok;
    logic       reserved_no;
    logic       unused_bits;

    assign ctype       = cmd_word[31:24];
    assign unused_bits = ^{cmd_word[23], cmd_word[19]};

    always_comb begin
        dec_cmd.size     = cmd_word[22:20];
        dec_cmd.postexec = cmd_word[18];
        dec_cmd.transfer = cmd_word[17];
        dec_cmd.write    = cmd_word[16];
        dec_cmd.regno    = cmd_word[15:0];
        if (cmd_word[15:12] == 4'h0)
            dec_cmd.region = REG_CSR;
        else if (cmd_word[15:5] == 11'h080)
            dec_cmd.region = REG_GPR;
        else if (cmd_word[15:5] == 11'h081)
            dec_cmd.region = REG_FPR;
        else
            dec_cmd.region = REG_OTHER;
    end

    assign size_ok     = (int'(cmd_word[22:20]) >= 2) && (int'(cmd_word[22:20]) <= MAX_SIZE)
                         && (int'(cmd_word[22:20]) <= 4);
    assign reserved_no = (cmd_word[15:14] == 2'b11);

    always_comb begin
        if (ctype != 8'd0)
            dec_err = ERR_UNSUP;
        else if (cmd_word[17] && (!size_ok || reserved_no))
            dec_err = ERR_UNSUP;
        else if (!hart_halted)
            dec_err = ERR_NOT_HALTED;
        else
            dec_err = ERR_NONE;
    end

endmodule

// File: rtl/abscmd_databank.sv
module abscmd_databank #(
    parameter int DATA_COUNT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr_en,
    input  logic [IDX_W-1:0]           bus_idx,
    input  logic [31:0]                bus_wdata,
    input  logic                       load_en,
    input  logic [2:0]                 size_code,
    input  logic [32*DATA_COUNT-1:0]   load_data,
    output logic [31:0]                rd_word,
    output logic [32*DATA_COUNT-1:0]   wr_view
);
    localparam int IDX_W = (DATA_COUNT > 1) ? $clog2(DATA_COUNT) : 1;

    logic [31:0] words_q [DATA_COUNT];
    logic [3:0]  word_cnt;

    always_comb begin
        if (size_code >= 3'd2 && size_code <= 3'd4)
            word_cnt = 4'd1 << (size_code - 3'd2);
        else
            word_cnt = 4'd1;
    end

    for (genvar i = 0; i < DATA_COUNT; i++) begin : g_word
        logic in_size;
        assign in_size = (i < int'(word_cnt));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words_q[i] <= '0;
            else if (load_en && in_size)
                words_q[i] <= load_data[32*i +: 32];
            else if (bus_wr_en && (int'(bus_idx) == i))
                words_q[i] <= bus_wdata;
        end

        assign wr_view[32*i +: 32] = in_size ? words_q[i] : 32'd0;
    end

    assign rd_word = words_q[bus_idx];

endmodule

// File: rtl/abscmd_fsm.sv
module abscmd_fsm
    import abscmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  cmd_t        cmd_in,
    input  logic        hreg_ready,
    input  logic        pexec_done,
    output logic        busy,
    output logic        hreg_valid,
    output logic        pexec_req,
    output logic        load_en,
    output cmd_t        cmd_q
);
    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (start && state_q == ST_IDLE)
            cmd_q <= cmd_in;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cmd_in.transfer)
                        state_d = ST_XFER;
                    else if (cmd_in.postexec)
                        state_d = ST_PEXEC;
                    else
                        state_d = ST_FINISH;
                end
            end
            ST_XFER: begin
                if (hreg_ready)
                    state_d = cmd_q.postexec ? ST_PEXEC : ST_FINISH;
            end
            ST_PEXEC: begin
                if (pexec_done)
                    state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        hreg_valid = (state_q == ST_XFER);
        pexec_req  = (state_q == ST_PEXEC);
        load_en    = (state_q == ST_XFER) && hreg_ready && !cmd_q.write;
    end

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hreg_valid && !hreg_ready |=> hreg_valid && $stable(cmd_q));

    // R7
    pexec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pexec_req && !pexec_done |=> pexec_req);

    // R7
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hreg_valid, pexec_req}));

endmodule

// File: rtl/abscmd_engine.sv
module abscmd_engine
    import abscmd_pkg::*;
#(
    parameter int DATA_COUNT    = 2,
    parameter int PROGBUF_WORDS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [6:0]                dbg_addr,
    input  logic [31:0]               dbg_wdata,
    input  logic                      dbg_wr,
    input  logic                      dbg_rd,
    output logic [31:0]               dbg_rdata,
    input  logic                      hart_halted,
    output logic                      hreg_valid,
    input  logic                      hreg_ready,
    output logic                      hreg_write,
    output logic [15:0]               hreg_regno,
    output logic [1:0]                hreg_region,
    output logic [2:0]                hreg_size,
    output logic [32*DATA_COUNT-1:0]  hreg_wdata,
    input  logic [32*DATA_COUNT-1:0]  hreg_rdata,
    output logic                      pexec_req,
    input  logic                      pexec_done
);
    localparam int         IDX_W   = (DATA_COUNT > 1) ? $clog2(DATA_COUNT) : 1;
    localparam logic [4:0] PB_SIZE = 5'(PROGBUF_WORDS);
    localparam logic [3:0] DC_SIZE = 4'(DATA_COUNT);

    logic [2:0]  cmderr_q;
    logic [2:0]  dec_err;
    cmd_t        dec_cmd, cmd_q;
    logic        busy, load_en, start;
    logic        wr_cmd, wr_status, wr_arg, rd_arg_hit;
    logic [6:0]  arg_off;
    logic [31:0] arg_word, status_word, rd_mux;

    assign arg_off    = dbg_addr - ADDR_ARG_BASE;
    assign rd_arg_hit = (dbg_addr >= ADDR_ARG_BASE) && (int'(arg_off) < DATA_COUNT);
    assign wr_cmd     = dbg_wr && (dbg_addr == ADDR_COMMAND);
    assign wr_status  = dbg_wr && (dbg_addr == ADDR_STATUS);
    assign wr_arg     = dbg_wr && rd_arg_hit;
    assign start      = wr_cmd && !busy && (cmderr_q == ERR_NONE) && (dec_err == ERR_NONE);

    abscmd_decode #(.DATA_COUNT(DATA_COUNT)) u_dec (
        .cmd_word    (dbg_wdata),
        .hart_halted (hart_halted),
        .dec_err     (dec_err),
        .dec_cmd     (dec_cmd)
    );

    abscmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_in     (dec_cmd),
        .hreg_ready (hreg_ready),
        .pexec_done (pexec_done),
        .busy       (busy),
        .hreg_valid (hreg_valid),
        .pexec_req  (pexec_req),
        .load_en    (load_en),
        .cmd_q      (cmd_q)
    );

    abscmd_databank #(.DATA_COUNT(DATA_COUNT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (wr_arg && !busy),
        .bus_idx   (arg_off[IDX_W-1:0]),
        .bus_wdata (dbg_wdata),
        .load_en   (load_en),
        .size_code (cmd_q.size),
        .load_data (hreg_rdata),
        .rd_word   (arg_word),
        .wr_view   (hreg_wdata)
    );

    assign hreg_write  = cmd_q.write;
    assign hreg_regno  = cmd_q.regno;
    assign hreg_region = cmd_q.region;
    assign hreg_size   = cmd_q.size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmderr_q <= ERR_NONE;
        else if (wr_status)
            cmderr_q <= cmderr_q & ~dbg_wdata[10:8];
        else if ((wr_cmd || wr_arg) && busy && cmderr_q == ERR_NONE)
            cmderr_q <= ERR_BUSY;
        else if (wr_cmd && !busy && cmderr_q == ERR_NONE)
            cmderr_q <= dec_err;
    end

    assign status_word = {3'b000, PB_SIZE, 11'd0, busy, 1'b0, cmderr_q, 4'd0, DC_SIZE};

    always_comb begin
        if (dbg_addr == ADDR_STATUS)
            rd_mux = status_word;
        else if (rd_arg_hit)
            rd_mux = arg_word;
        else
            rd_mux = 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dbg_rdata <= '0;
        else if (dbg_rd)
            dbg_rdata <= rd_mux;
    end

    // R12
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmderr_q != ERR_NONE) && !wr_status |=> cmderr_q == $past(cmderr_q));

    // R12
    no_start_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hreg_valid) |-> $past(cmderr_q) == ERR_NONE);

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_cmd));

endmodule

// File: tb/sim_abscmd_engine.sv
module sim_abscmd_engine;
    import abscmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic        dbg_wr = 1'b0, dbg_rd = 1'b0;
    logic [31:0] dbg_rdata;
    logic        hart_halted = 1'b1;
    logic        hreg_valid, hreg_ready = 1'b1, hreg_write;
    logic [15:0] hreg_regno;
    logic [1:0]  hreg_region;
    logic [2:0]  hreg_size;
    logic [63:0] hreg_wdata, hreg_rdata = '0;
    logic        pexec_req, pexec_done = 1'b0;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    abscmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_wr(dbg_wr), .dbg_rd(dbg_rd), .dbg_rdata(dbg_rdata),
        .hart_halted(hart_halted), .hreg_valid(hreg_valid), .hreg_ready(hreg_ready),
        .hreg_write(hreg_write), .hreg_regno(hreg_regno), .hreg_region(hreg_region),
        .hreg_size(hreg_size), .hreg_wdata(hreg_wdata), .hreg_rdata(hreg_rdata),
        .pexec_req(pexec_req), .pexec_done(pexec_done)
    );

    typedef struct packed {
        logic [31:0] cmd;
        logic        halted;
        logic [2:0]  err;
        logic        valid;
        logic        pexec;
        logic [1:0]  region;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{32'h00221005, 1'b1, 3'd0, 1'b1, 1'b0, 2'd1},  // R2 GPR read
        '{32'h003307B1, 1'b1, 3'd0, 1'b1, 1'b0, 2'd0},  // R2 CSR write
        '{32'h00261021, 1'b1, 3'd0, 1'b1, 1'b1, 2'd2},  // R7 FPR + postexec
        '{32'h0074FFFF, 1'b1, 3'd0, 1'b0, 1'b1, 2'd0},  // R6 no transfer, junk fields
        '{32'h00000000, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0},  // R6 empty command
        '{32'h01000000, 1'b1, 3'd2, 1'b0, 1'b0, 2'd0},  // R10 quick access
        '{32'h00421000, 1'b1, 3'd2, 1'b0, 1'b0, 2'd0},  // R10 size 4
        '{32'h0022C000, 1'b1, 3'd2, 1'b0, 1'b0, 2'd0},  // R10 reserved number
        '{32'h00221001, 1'b0, 3'd4, 1'b0, 1'b0, 2'd0},  // R11 running hart
        '{32'h01000000, 1'b0, 3'd2, 1'b0, 1'b0, 2'd0},  // R10 wins over R11
        '{32'h00221040, 1'b1, 3'd0, 1'b1, 1'b0, 2'd3}   // R2 other space
    };

    logic        seen_valid, seen_pexec, cap_write;
    logic [15:0] cap_regno;
    logic [1:0]  cap_region;
    logic [2:0]  cap_size;
    logic [63:0] cap_wdata;
    logic [31:0] rv;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        dbg_addr = a; dbg_wdata = d; dbg_wr = 1'b1;
        @(negedge clk);
        dbg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] v);
        dbg_addr = a; dbg_rd = 1'b1;
        @(negedge clk);
        dbg_rd = 1'b0;
        v = dbg_rdata;
    endtask

    task automatic do_cmd(input logic [31:0] c);
        bus_write(ADDR_COMMAND, c);
        seen_valid = 0; seen_pexec = 0;
        for (int k = 0; k < 8; k++) begin
            pexec_done = 1'b0;
            if (hreg_valid && !seen_valid) begin
                seen_valid = 1; cap_regno = hreg_regno; cap_region = hreg_region;
                cap_size = hreg_size; cap_write = hreg_write; cap_wdata = hreg_wdata;
            end
            if (pexec_req) begin
                seen_pexec = 1; pexec_done = 1'b1;
            end
            @(negedge clk);
        end
        pexec_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(ADDR_STATUS, rv);
        check("R1 status reset", rv, 32'h02000002);
        bus_read(ADDR_ARG_BASE, rv);
        check("R1 arg0 reset", rv, 0);
        check("R1 no request at reset", {hreg_valid, pexec_req}, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            hart_halted = VECS[v].halted;
            bus_write(ADDR_STATUS, 32'h00000700);
            do_cmd(VECS[v].cmd);
            check("R2/R6 request seen", seen_valid, VECS[v].valid);
            check("R7 exec seen", seen_pexec, VECS[v].pexec);
            if (VECS[v].valid) begin
                check("R2 regno", cap_regno, VECS[v].cmd[15:0]);
                check("R2 region", cap_region, VECS[v].region);
                check("R2 size", cap_size, VECS[v].cmd[22:20]);
                check("R2 write bit", cap_write, VECS[v].cmd[16]);
            end
            bus_read(ADDR_STATUS, rv);
            check("R10/R11 cmderr", rv[10:8], VECS[v].err);
            check("R8 idle after run", rv[12], 0);
        end
        hart_halted = 1'b1;
        bus_write(ADDR_STATUS, 32'h00000700);

        // R3 read direction
        hreg_rdata = 64'h11223344_55667788;
        do_cmd(32'h00321005);
        bus_read(ADDR_ARG_BASE, rv);
        check("R3 size3 low", rv, 32'h55667788);
        bus_read(ADDR_ARG_BASE + 7'd1, rv);
        check("R3 size3 high", rv, 32'h11223344);
        hreg_rdata = 64'hCAFEF00D_0BADC0DE;
        do_cmd(32'h00221005);
        bus_read(ADDR_ARG_BASE, rv);
        check("R3 size2 low", rv, 32'h0BADC0DE);
        bus_read(ADDR_ARG_BASE + 7'd1, rv);
        check("R3 size2 keeps high", rv, 32'h11223344);

        // R4 write direction
        bus_write(ADDR_ARG_BASE, 32'hA5A5A5A5);
        bus_write(ADDR_ARG_BASE + 7'd1, 32'h5A5A5A5A);
        do_cmd(32'h00331010);
        check("R4 size3 wdata", cap_wdata, 64'h5A5A5A5A_A5A5A5A5);
        do_cmd(32'h00231010);
        check("R4 size2 wdata", cap_wdata, 64'h00000000_A5A5A5A5);

        // R8/R9/R5 busy and stalled handshake
        bus_write(ADDR_ARG_BASE, 32'h12345678);
        hreg_ready = 1'b0;
        bus_write(ADDR_COMMAND, 32'h00231002);
        bus_read(ADDR_STATUS, rv);
        check("R8 busy after write", rv[12], 1);
        check("R8 no error yet", rv[10:8], 0);
        bus_write(ADDR_COMMAND, 32'h00221003);
        bus_write(ADDR_ARG_BASE, 32'hDEADBEEF);
        check("R5 valid held", hreg_valid, 1);
        check("R9 regno unchanged", hreg_regno, 16'h1002);
        check("R9 wdata unchanged", hreg_wdata[31:0], 32'h12345678);
        hreg_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 no restart", hreg_valid, 0);
        bus_read(ADDR_STATUS, rv);
        check("R9 busy error", rv[10:8], 1);
        check("R8 busy cleared", rv[12], 0);
        bus_read(ADDR_ARG_BASE, rv);
        check("R9 arg ignored", rv, 32'h12345678);

        // R12 sticky, partial clear
        bus_write(ADDR_STATUS, 32'h00000700);
        do_cmd(32'h01000000);
        hart_halted = 1'b0;
        do_cmd(32'h00221001);
        hart_halted = 1'b1;
        check("R12 no start on error", seen_valid, 0);
        bus_read(ADDR_STATUS, rv);
        check("R12 error kept", rv[10:8], 2);
        bus_write(ADDR_STATUS, 32'h00000100);
        bus_read(ADDR_STATUS, rv);
        check("R12 other bit kept", rv[10:8], 2);
        bus_write(ADDR_STATUS, 32'h00000200);
        bus_read(ADDR_STATUS, rv);
        check("R12 cleared", rv[10:8], 0);
        do_cmd(32'h00221001);
        check("R12 restart after clear", seen_valid, 1);

        // R7 exec waits for done
        bus_write(ADDR_COMMAND, 32'h00040000);
        repeat (4) @(negedge clk);
        check("R7 exec held", pexec_req, 1);
        bus_read(ADDR_STATUS, rv);
        check("R8 busy during exec", rv[12], 1);
        pexec_done = 1'b1;
        @(negedge clk);
        pexec_done = 1'b0;
        check("R7 exec dropped", pexec_req, 0);
        @(negedge clk);
        bus_read(ADDR_STATUS, rv);
        check("R8 busy after exec", rv[12], 0);
        check("R7 no error", rv[10:8], 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule